// File: doc/BRIEF.md
# Multiplexed Parallel I/O Bank Controller

This block manages a bank of 32 pads. Each pad is owned either by general-purpose logic or by one of two on-chip peripheral functions (A or B). For each pin it holds the output enable, output data, pull-up, input glitch filter, open-drain drive and interrupt mask. Software never writes a setting directly. It writes a pin bitmask to a dedicated "set" address or a dedicated "clear" address. Bits written as zero leave their pins alone, so drivers that share a bank cannot disturb each other's pins.

Every pad input passes through a two-flop synchronizer. It can then pass through an optional two-sample glitch filter before it becomes the pin's accepted level. A change of the accepted level in either direction latches a per-pin pending bit. The bank interrupt is raised while any pending bit is also enabled in the mask. Reading the pending register returns the bits and clears them in the same access.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is owned by general-purpose logic with its output disabled, output data 0, pull-up on, filter off, open-drain off, select A, interrupt mask 0 and pending bits 0. The interrupt output is low.
- R2: For each setting, a write to its set address ORs the write data into the setting and a write to its clear address removes those bits. Zero bits change nothing. The setting's status address reads it back. Offsets: ownership 0x00/0x04/0x08, output enable 0x10/0x14/0x18, filter 0x20/0x24/0x28, open-drain 0x50/0x54/0x58, interrupt mask 0x40/0x44/0x48.
- R3: A pin with ownership bit 0 takes its drive value and enable from peripheral A when its select bit is 0, and from peripheral B when the bit is 1. Select-A writes go to 0x70, select-B writes to 0x74, and the select status reads at 0x78 (1 = B).
- R4: A pin with ownership bit 1 drives its output data with its output enable. Data is set at 0x30, cleared at 0x34 and read at 0x38.
- R5: A pin in open-drain mode always presents drive value 0. It is enabled only when its selected enable is 1 and its selected data is 0.
- R6: The pull-up output equals the pull-up setting. 0x60 clears bits, 0x64 sets bits and 0x68 reads the setting (1 = on).
- R7: Address 0x3C returns the accepted level of every pin, whatever its ownership. Without the filter, a pad change appears at the third rising edge after it.
- R8: With the filter on, a change is accepted only after two equal consecutive synchronized samples, one edge later than unfiltered. A one-cycle pulse is never accepted.
- R9: A rising or falling change of a pin's accepted level sets that pin's bit in the pending register (0x4C) at the same edge.
- R10: Reading 0x4C returns the pending bits and clears them. A change accepted at the read edge stays pending.
- R11: The interrupt output is high exactly when some pending bit is also set in the mask.
- R12: Read data appears on the edge after the read strobe. Set/clear-only addresses and unmapped addresses read as 0. When no read is strobed, the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data / pin mask |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels |
| pad_out | output | 32 | Pad drive values |
| pad_oe | output | 32 | Pad drive enables |
| pad_pullup | output | 32 | Pull-up enables |
| pa_out | input | 32 | Peripheral A drive values |
| pa_oe | input | 32 | Peripheral A enables |
| pb_out | input | 32 | Peripheral B drive values |
| pb_oe | input | 32 | Peripheral B enables |
| irq | output | 1 | Bank interrupt |

## Verification
Register writes reach the pad outputs straight after the write edge, because the pad multiplexing is combinational from the stored settings. Read data is due one edge after the strobe. An unfiltered pad change reaches the pin status and the pending register at the third edge, and a filtered change at the fourth. The bench model keeps a three-deep history of sampled pad values, so it predicts exactly those edges and compares all outputs a quarter period after every edge. Directed reads also probe the cycle just before a filtered change is due, so an early or late acceptance shows up as a mismatch.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] A_OWN_EN  = 8'h00;
    localparam logic [ADDR_W-1:0] A_OWN_DIS = 8'h04;
    localparam logic [ADDR_W-1:0] A_OWN_ST  = 8'h08;
    localparam logic [ADDR_W-1:0] A_OE_EN   = 8'h10;
    localparam logic [ADDR_W-1:0] A_OE_DIS  = 8'h14;
    localparam logic [ADDR_W-1:0] A_OE_ST   = 8'h18;
    localparam logic [ADDR_W-1:0] A_FLT_EN  = 8'h20;
    localparam logic [ADDR_W-1:0] A_FLT_DIS = 8'h24;
    localparam logic [ADDR_W-1:0] A_FLT_ST  = 8'h28;
    localparam logic [ADDR_W-1:0] A_DAT_SET = 8'h30;
    localparam logic [ADDR_W-1:0] A_DAT_CLR = 8'h34;
    localparam logic [ADDR_W-1:0] A_DAT_ST  = 8'h38;
    localparam logic [ADDR_W-1:0] A_PIN_ST  = 8'h3C;
    localparam logic [ADDR_W-1:0] A_IRQ_EN  = 8'h40;
    localparam logic [ADDR_W-1:0] A_IRQ_DIS = 8'h44;
    localparam logic [ADDR_W-1:0] A_IRQ_MSK = 8'h48;
    localparam logic [ADDR_W-1:0] A_IRQ_PND = 8'h4C;
    localparam logic [ADDR_W-1:0] A_OD_EN   = 8'h50;
    localparam logic [ADDR_W-1:0] A_OD_DIS  = 8'h54;
    localparam logic [ADDR_W-1:0] A_OD_ST   = 8'h58;
    localparam logic [ADDR_W-1:0] A_PU_DIS  = 8'h60;
    localparam logic [ADDR_W-1:0] A_PU_EN   = 8'h64;
    localparam logic [ADDR_W-1:0] A_PU_ST   = 8'h68;
    localparam logic [ADDR_W-1:0] A_SEL_A   = 8'h70;
    localparam logic [ADDR_W-1:0] A_SEL_B   = 8'h74;
    localparam logic [ADDR_W-1:0] A_SEL_ST  = 8'h78;
endpackage

// File: rtl/pio_input_cond.sv
module pio_input_cond #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pad_i,
    input  logic [N-1:0] filt_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] change_o
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] s3;
        logic [N-1:0] lvl;
    } cond_t;

    cond_t cur_q, nxt_d;
    logic [N-1:0] lvl_nx;

    // per-pin accept rule: filtered pins keep their level until two samples agree
    for (genvar g = 0; g < N; g++) begin : g_pin
        assign lvl_nx[g] = (filt_i[g] && (cur_q.s2[g] != cur_q.s3[g])) ? cur_q.lvl[g] : cur_q.s2[g];
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.s1  = pad_i;
        nxt_d.s2  = cur_q.s1;
        nxt_d.s3  = cur_q.s2;
        nxt_d.lvl = lvl_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '0;
        else     cur_q <= nxt_d;
    end

    assign level_o  = cur_q.lvl;
    assign change_o = lvl_nx ^ cur_q.lvl;

    // R8
    filt_accept_chk: assert property (@(posedge clk) disable iff (rst)
        ((cur_q.lvl ^ $past(cur_q.lvl)) & $past(filt_i) & ($past(cur_q.s2) ^ $past(cur_q.s3))) == '0);
endmodule

// File: rtl/pio_pad_mux.sv
module pio_pad_mux #(
    parameter int N = 32
) (
    input  logic [N-1:0] own_i,
    input  logic [N-1:0] selb_i,
    input  logic [N-1:0] od_i,
    input  logic [N-1:0] data_i,
    input  logic [N-1:0] oe_i,
    input  logic [N-1:0] pa_out_i,
    input  logic [N-1:0] pa_oe_i,
    input  logic [N-1:0] pb_out_i,
    input  logic [N-1:0] pb_oe_i,
    output logic [N-1:0] pad_out_o,
    output logic [N-1:0] pad_oe_o
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic v_sel, e_sel;
        always_comb begin
            if (own_i[g]) begin
                v_sel = data_i[g];
                e_sel = oe_i[g];
            end else if (selb_i[g]) begin
                v_sel = pb_out_i[g];
                e_sel = pb_oe_i[g];
            end else begin
                v_sel = pa_out_i[g];
                e_sel = pa_oe_i[g];
            end
        end
        assign pad_out_o[g] = od_i[g] ? 1'b0 : v_sel;
        assign pad_oe_o[g]  = od_i[g] ? (e_sel & ~v_sel) : e_sel;
    end
endmodule

// File: rtl/pio_bank.sv
module pio_bank
    import pio_pkg::*;
#(
    parameter int N = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [N-1:0]      bus_wdata,
    output logic [N-1:0]      bus_rdata,
    input  logic [N-1:0]      pad_in,
    output logic [N-1:0]      pad_out,
    output logic [N-1:0]      pad_oe,
    output logic [N-1:0]      pad_pullup,
    input  logic [N-1:0]      pa_out,
    input  logic [N-1:0]      pa_oe,
    input  logic [N-1:0]      pb_out,
    input  logic [N-1:0]      pb_oe,
    output logic              irq
);
    typedef struct packed {
        logic [N-1:0] own;
        logic [N-1:0] oe;
        logic [N-1:0] flt;
        logic [N-1:0] dat;
        logic [N-1:0] msk;
        logic [N-1:0] pnd;
        logic [N-1:0] od;
        logic [N-1:0] pu;
        logic [N-1:0] selb;
        logic [N-1:0] rdata;
    } regs_t;

    localparam regs_t RST_VAL = '{own: '1, pu: '1, default: '0};

    regs_t cur_q, nxt_d;
    logic  wr_en, rd_en, rd_pnd;
    logic [N-1:0] level, chg, pnd_base;

    assign wr_en  = bus_sel & bus_wr;
    assign rd_en  = bus_sel & ~bus_wr;
    assign rd_pnd = rd_en && (bus_addr == A_IRQ_PND);

    pio_input_cond #(.N(N)) u_cond (
        .clk      (clk),
        .rst      (rst),
        .pad_i    (pad_in),
        .filt_i   (cur_q.flt),
        .level_o  (level),
        .change_o (chg)
    );

    pio_pad_mux #(.N(N)) u_mux (
        .own_i     (cur_q.own),
        .selb_i    (cur_q.selb),
        .od_i      (cur_q.od),
        .data_i    (cur_q.dat),
        .oe_i      (cur_q.oe),
        .pa_out_i  (pa_out),
        .pa_oe_i   (pa_oe),
        .pb_out_i  (pb_out),
        .pb_oe_i   (pb_oe),
        .pad_out_o (pad_out),
        .pad_oe_o  (pad_oe)
    );

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.rdata = '0;
        pnd_base    = cur_q.pnd;
        if (rd_en) begin
            case (bus_addr)
                A_OWN_ST:  nxt_d.rdata = cur_q.own;
                A_OE_ST:   nxt_d.rdata = cur_q.oe;
                A_FLT_ST:  nxt_d.rdata = cur_q.flt;
                A_DAT_ST:  nxt_d.rdata = cur_q.dat;
                A_PIN_ST:  nxt_d.rdata = level;
                A_IRQ_MSK: nxt_d.rdata = cur_q.msk;
                A_IRQ_PND: begin
                    nxt_d.rdata = cur_q.pnd;
                    pnd_base    = '0;
                end
                A_OD_ST:   nxt_d.rdata = cur_q.od;
                A_PU_ST:   nxt_d.rdata = cur_q.pu;
                A_SEL_ST:  nxt_d.rdata = cur_q.selb;
                default:   nxt_d.rdata = '0;
            endcase
        end
        if (wr_en) begin
            case (bus_addr)
                A_OWN_EN:  nxt_d.own  = cur_q.own  |  bus_wdata;
                A_OWN_DIS: nxt_d.own  = cur_q.own  & ~bus_wdata;
                A_OE_EN:   nxt_d.oe   = cur_q.oe   |  bus_wdata;
                A_OE_DIS:  nxt_d.oe   = cur_q.oe   & ~bus_wdata;
                A_FLT_EN:  nxt_d.flt  = cur_q.flt  |  bus_wdata;
                A_FLT_DIS: nxt_d.flt  = cur_q.flt  & ~bus_wdata;
                A_DAT_SET: nxt_d.dat  = cur_q.dat  |  bus_wdata;
                A_DAT_CLR: nxt_d.dat  = cur_q.dat  & ~bus_wdata;
                A_IRQ_EN:  nxt_d.msk  = cur_q.msk  |  bus_wdata;
                A_IRQ_DIS: nxt_d.msk  = cur_q.msk  & ~bus_wdata;
                A_OD_EN:   nxt_d.od   = cur_q.od   |  bus_wdata;
                A_OD_DIS:  nxt_d.od   = cur_q.od   & ~bus_wdata;
                A_PU_EN:   nxt_d.pu   = cur_q.pu   |  bus_wdata;
                A_PU_DIS:  nxt_d.pu   = cur_q.pu   & ~bus_wdata;
                A_SEL_B:   nxt_d.selb = cur_q.selb |  bus_wdata;
                A_SEL_A:   nxt_d.selb = cur_q.selb & ~bus_wdata;
                default:   ;
            endcase
        end
        nxt_d.pnd = pnd_base | chg;
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= RST_VAL;
        else     cur_q <= nxt_d;
    end

    assign bus_rdata  = cur_q.rdata;
    assign pad_pullup = cur_q.pu;
    assign irq        = |(cur_q.pnd & cur_q.msk);

    // R2
    oe_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && bus_addr == A_OE_EN) |=> ((cur_q.oe & $past(bus_wdata)) == $past(bus_wdata)));
    // R9
    pnd_set_chk: assert property (@(posedge clk) disable iff (rst)
        (|chg) |=> ((cur_q.pnd & $past(chg)) == $past(chg)));
    // R10
    pnd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_pnd |=> (cur_q.pnd == $past(chg)));
    // R5
    od_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (pad_out & cur_q.od) == '0);
endmodule

// File: tb/pio_bank_test.sv
module pio_bank_test;
    localparam int PER = 10;

    logic        clk = 0, rst = 1;
    logic        bus_sel = 0, bus_wr = 0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] pad_in = '0, pad_out, pad_oe, pad_pullup;
    logic [31:0] pa_out = '0, pa_oe = '0, pb_out = '0, pb_oe = '0;
    logic        irq;

    int n_chk = 0, n_fail = 0;

    always #(PER/2) clk = ~clk;

    pio_bank uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .pad_pullup(pad_pullup), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_out(pb_out), .pb_oe(pb_oe), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // behavioural reference model
    logic [31:0] m_own, m_oe, m_flt, m_dat, m_msk, m_pnd, m_od, m_pu, m_selb, m_lvl, e_rd;
    logic [31:0] hist[$];

    always @(posedge clk) begin
        logic [31:0] raw, prv, nl, base, eo, ee;
        if (rst) begin
            m_own = '1; m_pu = '1;
            m_oe = 0; m_flt = 0; m_dat = 0; m_msk = 0; m_pnd = 0; m_od = 0; m_selb = 0;
            m_lvl = 0; e_rd = 0;
            hist = '{32'h0, 32'h0, 32'h0};
        end else begin
            raw = hist[1]; prv = hist[2];
            for (int b = 0; b < 32; b++)
                nl[b] = (m_flt[b] && raw[b] != prv[b]) ? m_lvl[b] : raw[b];
            e_rd = 0; base = m_pnd;
            if (bus_sel && !bus_wr) begin
                case (bus_addr)
                    8'h08: e_rd = m_own;  8'h18: e_rd = m_oe;   8'h28: e_rd = m_flt;
                    8'h38: e_rd = m_dat;  8'h3C: e_rd = m_lvl;  8'h48: e_rd = m_msk;
                    8'h4C: begin e_rd = m_pnd; base = 0; end
                    8'h58: e_rd = m_od;   8'h68: e_rd = m_pu;   8'h78: e_rd = m_selb;
                    default: e_rd = 0;
                endcase
            end
            if (bus_sel && bus_wr) begin
                case (bus_addr)
                    8'h00: m_own |= bus_wdata;  8'h04: m_own &= ~bus_wdata;
                    8'h10: m_oe  |= bus_wdata;  8'h14: m_oe  &= ~bus_wdata;
                    8'h20: m_flt |= bus_wdata;  8'h24: m_flt &= ~bus_wdata;
                    8'h30: m_dat |= bus_wdata;  8'h34: m_dat &= ~bus_wdata;
                    8'h40: m_msk |= bus_wdata;  8'h44: m_msk &= ~bus_wdata;
                    8'h50: m_od  |= bus_wdata;  8'h54: m_od  &= ~bus_wdata;
                    8'h64: m_pu  |= bus_wdata;  8'h60: m_pu  &= ~bus_wdata;
                    8'h74: m_selb |= bus_wdata; 8'h70: m_selb &= ~bus_wdata;
                    default: ;
                endcase
            end
            m_pnd = base | (nl ^ m_lvl);
            m_lvl = nl;
            hist.push_front(pad_in);
            void'(hist.pop_back());
        end
        #(PER/4);
        for (int b = 0; b < 32; b++) begin
            logic v, e;
            if (m_own[b]) begin v = m_dat[b]; e = m_oe[b]; end
            else if (m_selb[b]) begin v = pb_out[b]; e = pb_oe[b]; end
            else begin v = pa_out[b]; e = pa_oe[b]; end
            eo[b] = m_od[b] ? 1'b0 : v;
            ee[b] = m_od[b] ? (e & ~v) : e;
        end
        chk("R3/R4/R5 pad_out model", pad_out, eo);
        chk("R3/R4/R5 pad_oe model", pad_oe, ee);
        chk("R6 pullup model", pad_pullup, m_pu);
        chk("R11 irq model", {31'b0, irq}, {31'b0, |(m_pnd & m_msk)});
        chk("R12 rdata model", bus_rdata, e_rd);
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_sel = 0; bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(posedge clk); #(PER/4); d = bus_rdata;
        @(negedge clk); bus_sel = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd(8'h08, v); chk("R1 ownership", v, 32'hFFFF_FFFF);
        rd(8'h18, v); chk("R1 output enable", v, 0);
        rd(8'h68, v); chk("R1 pull-up", v, 32'hFFFF_FFFF);
        rd(8'h48, v); chk("R1 mask", v, 0);
        rd(8'h4C, v); chk("R1 pending", v, 0);
        chk("R1 irq low", {31'b0, irq}, 0);
        // R12 set-only address reads 0
        rd(8'h00, v); chk("R12 write-only reads 0", v, 0);
        // R2 set/clear
        wr(8'h10, 32'hF0); wr(8'h14, 32'h30);
        rd(8'h18, v); chk("R2 oe set/clear", v, 32'hC0);
        wr(8'h14, 32'h0);
        rd(8'h18, v); chk("R2 zero mask no effect", v, 32'hC0);
        // R4 gpio drive
        wr(8'h30, 32'hFF);
        rd(8'h38, v); chk("R4 data status", v, 32'hFF);
        chk("R4 pad_out", pad_out & 32'hFF, 32'hFF);
        chk("R4 pad_oe", pad_oe & 32'hFF, 32'hC0);
        wr(8'h34, 32'h0F);
        rd(8'h38, v); chk("R4 data clear", v, 32'hF0);
        // R3 peripheral ownership
        pa_out = 32'h100; pa_oe = 32'h100; pb_out = 0; pb_oe = 32'h100;
        wr(8'h04, 32'h100);
        chk("R3 periph A out", pad_out & 32'h100, 32'h100);
        wr(8'h74, 32'h100);
        rd(8'h78, v); chk("R3 select status", v, 32'h100);
        chk("R3 periph B out", pad_out & 32'h100, 0);
        chk("R3 periph B oe", pad_oe & 32'h100, 32'h100);
        // R5 open drain
        wr(8'h50, 32'h80);
        chk("R5 od high floats", pad_oe & 32'h80, 0);
        wr(8'h34, 32'h80);
        chk("R5 od low drives", pad_oe & 32'h80, 32'h80);
        chk("R5 od value 0", pad_out & 32'h80, 0);
        // R6 pull-up
        wr(8'h60, 32'hF);
        chk("R6 pull-up clear", pad_pullup, 32'hFFFF_FFF0);
        wr(8'h64, 32'h3);
        rd(8'h68, v); chk("R6 pull-up status", v, 32'hFFFF_FFF3);
        // R7 / R9 / R10
        rd(8'h4C, v);
        pad_in = 32'h108;
        repeat (2) @(negedge clk);
        rd(8'h3C, v); chk("R7 pin status incl periph pin", v, 32'h108);
        rd(8'h4C, v); chk("R9 rising pending", v, 32'h108);
        rd(8'h4C, v); chk("R10 cleared by read", v, 0);
        pad_in = 32'h100;
        repeat (3) @(negedge clk);
        rd(8'h4C, v); chk("R9 falling pending", v, 32'h8);
        // R11 irq
        wr(8'h40, 32'h8);
        chk("R11 irq low with nothing pending", {31'b0, irq}, 0);
        pad_in = 32'h108;
        repeat (4) @(negedge clk);
        chk("R11 irq high", {31'b0, irq}, 1);
        rd(8'h4C, v); chk("R11 pending", v, 32'h8);
        chk("R11 irq low after read", {31'b0, irq}, 0);
        rd(8'h48, v); chk("R2 mask status", v, 32'h8);
        wr(8'h44, 32'h8);
        // R8 glitch filter
        wr(8'h20, 32'h10);
        rd(8'h28, v); chk("R8 filter status", v, 32'h10);
        @(negedge clk); pad_in = 32'h118;
        @(negedge clk); pad_in = 32'h108;
        repeat (5) @(negedge clk);
        rd(8'h4C, v); chk("R8 pulse rejected", v, 0);
        pad_in = 32'h118;
        repeat (2) @(negedge clk);
        rd(8'h3C, v); chk("R8 not yet accepted", v, 32'h108);
        rd(8'h3C, v); chk("R8 accepted", v, 32'h118);
        rd(8'h4C, v); chk("R8 pending after accept", v, 32'h10);
        // unfiltered pulse passes
        @(negedge clk); pad_in = 32'h138;
        @(negedge clk); pad_in = 32'h118;
        repeat (5) @(negedge clk);
        rd(8'h4C, v); chk("R8 unfiltered pulse seen", v, 32'h20);
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule